// File: doc/BRIEF.md
# Host Command Byte Decoder

This block sits behind a host link that delivers one byte at a time. It splits the stream into commands, each made of an opcode byte and a payload whose length is fixed by the opcode. The block holds the generator's configuration fields as registers, opens and closes waveform transfers, and returns the fixed reply bytes that each command calls for. While a transfer is open, the announced number of sample points arrives as byte pairs. The block assembles each pair into a 16-bit word and presents it on a one-cycle strobe.

The byte input and the reply output both use a valid/ready handshake. The block takes no new byte while any reply byte is still waiting, so the order of replies always follows the order of commands. The 0xA2 command has two forms: one with a six-byte payload and one with no payload. The block tells them apart by the byte that follows the opcode. A payload always begins with 0x00, and no command opcode is 0x00.

Top module: `host_cmd_decoder`

## Requirements
- R1: After reset, in_ready is 1, rsp_valid and smp_valid are 0, xfer_open is 0, and every configuration and count output is 0.
- R2: Opcode 0xA0 takes six payload bytes. Only when the sixth byte is accepted do the fields update, as follows. Payload byte 1 goes to cfg_mode. Bit 0 of byte 2 goes to cfg_out_sel. Byte 3 goes to cfg_dio[7:0]. The low nibble of byte 4 goes to cfg_dio[11:8], and the upper nibble of byte 4 is ignored. Byte 5 goes to cfg_clkdiv. Byte 6 is ignored. The fields do not change at any other time.
- R3: After its sixth payload byte, opcode 0xA0 is answered with ten reply bytes, all 0x00.
- R4: Opcode 0xA1 takes two payload bytes. The point count is {byte2[3:0], byte1}. If bit 7 of byte 2 is 1, xfer_open is set and xfer_count takes the count. If bit 7 is 0, xfer_open is cleared and any points still outstanding are dropped. The reply is the single byte 0xCC.
- R5: While a transfer is open and points are still outstanding, each pair of input bytes forms one sample with the first byte as bits [15:8]. The sample appears on smp_data with a one-cycle smp_valid pulse in the cycle after the second byte is accepted. Once xfer_count samples have been delivered, input bytes are parsed as opcodes again.
- R6: Opcode 0xA2 is answered with 0xCD. If the next byte is 0x00, that byte and the five bytes after it are consumed as payload. Any other next byte is parsed as an opcode.
- R7: Opcode 0xA3 has no payload and is answered with 0x02.
- R8: A byte in opcode position that is none of 0xA0 to 0xA3 is dropped with no reply, and the block keeps waiting for an opcode.
- R9: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data holds its value. in_ready is 0 whenever a reply byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| rsp_valid | output | 1 | Reply byte present |
| rsp_ready | input | 1 | Host takes the reply byte |
| rsp_data | output | 8 | Reply byte |
| cfg_mode | output | 8 | Mode field |
| cfg_out_sel | output | 1 | 0 pattern generator, 1 programmable output |
| cfg_dio | output | 12 | Digital I/O pin levels |
| cfg_clkdiv | output | 8 | Divider of the 48 kHz base clock |
| xfer_open | output | 1 | Waveform transfer in progress |
| xfer_count | output | 12 | Point count of the last transfer start |
| smp_valid | output | 1 | Sample word strobe |
| smp_data | output | 16 | Assembled sample word |

## Verification
Two events can fall in the same cycle: the host draining a reply byte and the block being asked to accept the next command byte. The bench keeps in_valid high with the next opcode ready, and it pulses rsp_ready in an irregular pattern in a second phase. Under these conditions a reply drain and a pending input byte meet on many clock edges. On every clock a behavioural queue model judges whether in_ready stayed low until the final reply byte left, and whether reply order and content survived the stalls. A further collision is an 0xA2 opcode followed at once by another opcode. Here the byte after 0xA2 has to be parsed as a command, not swallowed as payload.

// File: rtl/host_cmd_decoder.sv
module host_cmd_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  output logic [7:0]  cfg_mode,
  output logic        cfg_out_sel,
  output logic [11:0] cfg_dio,
  output logic [7:0]  cfg_clkdiv,
  output logic        xfer_open,
  output logic [11:0] xfer_count,
  output logic        smp_valid,
  output logic [15:0] smp_data
);
  localparam logic [7:0] OP_CFG = 8'hA0;
  localparam logic [7:0] OP_IND = 8'hA1;
  localparam logic [7:0] OP_AUX = 8'hA2;
  localparam logic [7:0] OP_QRY = 8'hA3;
  localparam logic [3:0] CFG_RSP_LEN = 4'd10;
  localparam logic [2:0] CFG_LAST = 3'd5;
  localparam logic [2:0] SKIP_LAST = 3'd4;

  typedef enum logic [2:0] {S_OP, S_CFG, S_IND, S_PEEK, S_SKIP, S_SLO} st_t;

  st_t         st;
  logic [2:0]  idx;
  logic [3:0]  rsp_left;
  logic [7:0]  rsp_byte;
  logic [7:0]  sh_mode, sh_dio_lo, sh_div, sh_lo, hi;
  logic        sh_sel;
  logic [3:0]  sh_dio_hi;
  logic [11:0] smp_left;

  assign in_ready  = (rsp_left == '0);
  assign rsp_valid = (rsp_left != '0);
  assign rsp_data  = rsp_byte;

  wire acc    = in_valid && in_ready;
  wire rsp_go = rsp_valid && rsp_ready;
  wire as_op  = (st == S_OP && smp_left == '0) || (st == S_PEEK && in_data != 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OP; idx <= '0; rsp_left <= '0; rsp_byte <= '0;
      sh_mode <= '0; sh_dio_lo <= '0; sh_div <= '0; sh_lo <= '0; hi <= '0;
      sh_sel <= 1'b0; sh_dio_hi <= '0; smp_left <= '0;
      cfg_mode <= '0; cfg_out_sel <= 1'b0; cfg_dio <= '0; cfg_clkdiv <= '0;
      xfer_open <= 1'b0; xfer_count <= '0; smp_valid <= 1'b0; smp_data <= '0;
    end else begin
      smp_valid <= 1'b0;
      if (rsp_go) rsp_left <= rsp_left - 4'd1;
      if (acc) begin
        if (as_op) begin
          st  <= S_OP;
          idx <= '0;
          case (in_data)
            OP_CFG: st <= S_CFG;
            OP_IND: st <= S_IND;
            OP_AUX: begin st <= S_PEEK; rsp_byte <= 8'hCD; rsp_left <= 4'd1; end
            OP_QRY: begin rsp_byte <= 8'h02; rsp_left <= 4'd1; end
            default: ;
          endcase
        end else begin
          case (st)
            S_OP: begin hi <= in_data; st <= S_SLO; end
            S_SLO: begin
              smp_data  <= {hi, in_data};
              smp_valid <= 1'b1;
              smp_left  <= smp_left - 12'd1;
              st        <= S_OP;
            end
            S_CFG: begin
              idx <= idx + 3'd1;
              case (idx)
                3'd0: sh_mode   <= in_data;
                3'd1: sh_sel    <= in_data[0];
                3'd2: sh_dio_lo <= in_data;
                3'd3: sh_dio_hi <= in_data[3:0];
                3'd4: sh_div    <= in_data;
                default: ;
              endcase
              if (idx == CFG_LAST) begin
                cfg_mode    <= sh_mode;
                cfg_out_sel <= sh_sel;
                cfg_dio     <= {sh_dio_hi, sh_dio_lo};
                cfg_clkdiv  <= sh_div;
                rsp_byte    <= 8'h00;
                rsp_left    <= CFG_RSP_LEN;
                st          <= S_OP;
              end
            end
            S_IND: begin
              if (idx == '0) begin
                sh_lo <= in_data;
                idx   <= 3'd1;
              end else begin
                if (in_data[7]) begin
                  xfer_open  <= 1'b1;
                  xfer_count <= {in_data[3:0], sh_lo};
                  smp_left   <= {in_data[3:0], sh_lo};
                end else begin
                  xfer_open <= 1'b0;
                  smp_left  <= '0;
                end
                rsp_byte <= 8'hCC;
                rsp_left <= 4'd1;
                st       <= S_OP;
              end
            end
            S_PEEK: begin st <= S_SKIP; idx <= '0; end
            S_SKIP: begin
              idx <= idx + 3'd1;
              if (idx == SKIP_LAST) st <= S_OP;
            end
            default: st <= S_OP;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/host_cmd_decoder_chk.sv
module host_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic [7:0]  cfg_mode,
  input logic        cfg_out_sel,
  input logic [11:0] cfg_dio,
  input logic [7:0]  cfg_clkdiv,
  input logic        xfer_open,
  input logic        smp_valid
);
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable({cfg_mode, cfg_out_sel, cfg_dio, cfg_clkdiv}));

  p_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(xfer_open));

  p_smp_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> xfer_open);

  p_smp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
endmodule

bind host_cmd_decoder host_cmd_decoder_chk u_chk (.*);

// File: tb/host_cmd_decoder_test.sv
module host_cmd_decoder_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, rsp_valid, rsp_ready, cfg_out_sel, xfer_open, smp_valid;
  logic [7:0] in_data, rsp_data, cfg_mode, cfg_clkdiv;
  logic [11:0] cfg_dio, xfer_count;
  logic [15:0] smp_data;

  host_cmd_decoder uut (.*);

  logic [7:0] tx[$];
  logic [7:0] eq[$];
  string      et[$];
  int checks = 0, errors = 0, nsmp = 0, ps = 0, pidx = 0, m_left = 0;
  bit hs_in = 0, stall = 0, done = 0;
  logic [7:0] mb[6];
  logic [7:0] m_hi = 0, m_lo = 0, em_mode = 0, em_div = 0;
  logic [11:0] em_dio = 0, m_cnt = 0;
  logic em_sel = 0, m_open = 0, m_sv = 0;
  logic [15:0] m_sd = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    eq.push_back(b); et.push_back(tag);
  endtask

  task automatic op(input logic [7:0] b);
    pidx = 0;
    case (b)
      8'hA0: ps = 1;
      8'hA1: ps = 2;
      8'hA2: begin push(8'hCD, "R6"); ps = 3; end
      8'hA3: push(8'h02, "R7");
      default: ps = 0; // R8: dropped, no reply
    endcase
  endtask

  task automatic parse(input logic [7:0] b);
    case (ps)
      0: if (m_left > 0) begin m_hi = b; ps = 5; end else op(b);
      5: begin m_sv = 1; m_sd = {m_hi, b}; m_left--; nsmp++; ps = 0; end
      1: begin
        mb[pidx] = b; pidx++;
        if (pidx == 6) begin
          em_mode = mb[0]; em_sel = mb[1][0]; em_dio = {mb[3][3:0], mb[2]}; em_div = mb[4];
          for (int i = 0; i < 10; i++) push(8'h00, "R3");
          ps = 0;
        end
      end
      2: if (pidx == 0) begin m_lo = b; pidx = 1; end
         else begin
           if (b[7]) begin m_open = 1; m_cnt = {b[3:0], m_lo}; m_left = int'({b[3:0], m_lo}); end
           else begin m_open = 0; m_left = 0; end
           push(8'hCC, "R4"); ps = 0;
         end
      3: if (b == 8'h00) begin ps = 4; pidx = 0; end else begin ps = 0; op(b); end
      4: begin pidx++; if (pidx == 5) ps = 0; end
      default: ps = 0;
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(in_ready == (eq.size() == 0), "R9 in_ready", in_ready, eq.size() == 0);
      chk(rsp_valid == (eq.size() != 0), "R8 R9 rsp_valid", rsp_valid, eq.size() != 0);
      if (rsp_valid && eq.size() != 0) chk(rsp_data == eq[0], et[0], rsp_data, eq[0]);
      chk({cfg_mode, cfg_out_sel, cfg_dio, cfg_clkdiv} == {em_mode, em_sel, em_dio, em_div},
          "R2 cfg", {cfg_mode, cfg_out_sel, cfg_dio, cfg_clkdiv}, {em_mode, em_sel, em_dio, em_div});
      chk({xfer_open, xfer_count} == {m_open, m_cnt}, "R4 xfer", {xfer_open, xfer_count}, {m_open, m_cnt});
      chk(smp_valid == m_sv, "R5 smp_valid", smp_valid, m_sv);
      if (smp_valid && m_sv) chk(smp_data == m_sd, "R5 smp_data", smp_data, m_sd);
      m_sv = 0;
      hs_in = in_valid && in_ready;
      if (rsp_valid && rsp_ready && eq.size() != 0) begin void'(eq.pop_front()); void'(et.pop_front()); end
      if (hs_in) parse(in_data);
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      if (hs_in) begin void'(tx.pop_front()); hs_in = 0; end
      if (!in_valid || !in_ready) in_valid = (tx.size() > 0) && (lfsr[0] || !stall);
      if (tx.size() == 0) in_valid = 0;
      in_data = (tx.size() > 0) ? tx[0] : 8'h00;
      rsp_ready = stall ? lfsr[3] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  task automatic send(input logic [7:0] b[]);
    foreach (b[i]) tx.push_back(b[i]);
  endtask

  task automatic drain();
    while (tx.size() != 0 || eq.size() != 0 || in_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    chk(in_ready && !rsp_valid && !smp_valid && !xfer_open, "R1 handshake", {in_ready, rsp_valid, smp_valid, xfer_open}, 4'b1000);
    chk({cfg_mode, cfg_out_sel, cfg_dio, cfg_clkdiv, xfer_count} == '0, "R1 fields",
        {cfg_mode, cfg_out_sel, cfg_dio, cfg_clkdiv}, 0);
    rst_n = 1;
    for (int ph = 0; ph < 2; ph++) begin
      stall = (ph == 1);
      send('{8'hA3});
      send('{8'h55});
      send('{8'hA0, 8'h3C, 8'h01, 8'hA5, 8'hF7, 8'h30, 8'h99});
      send('{8'hA1, 8'h03, 8'h80, 8'h12, 8'h34, 8'hAB, 8'hCD, 8'h00, 8'hFF});
      send('{8'hA1, 8'h00, 8'h00});
      send('{8'hA2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h30, 8'h00, 8'hA3});
      send('{8'hA2, 8'hA3});
      send('{8'hA1, 8'h00, 8'h80, 8'hA3, 8'hA1, 8'h00, 8'h00});
      send('{8'hA0, 8'hC3, 8'hFE, 8'h5A, 8'h08, 8'h07, 8'h00});
      drain();
    end
    chk(nsmp == 6, "R5 sample total", nsmp, 6);
    chk(cfg_dio == 12'h85A, "R2 upper nibble ignored", cfg_dio, 12'h85A);
    chk(!xfer_open, "R4 closed", xfer_open, 0);
    send('{8'h00, 8'hFF});
    drain();
    chk(!rsp_valid && in_ready, "R8 unknown dropped", {rsp_valid, in_ready}, 2'b01);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule